// File: doc/BRIEF.md
# Dual-Issue Dispatch Gate

The dispatch gate sits between an instruction queue and three execution units: integer, load/store and system-register. Each cycle the queue presents up to two decoded instructions, its oldest in slot 0 and the next in slot 1. The gate decides which of them may leave the queue now. It reports a grant per slot and a queue-advance count. Each instruction carries a target unit code, two optional source registers, an optional destination register and a serializing flag.

The gate keeps three pieces of state. The first is a busy-bit scoreboard with one bit per architectural register. The second is a count of instructions in flight, fed by a retire count from the completion side. The third is a two-state controller. In `ST_RUN` the gate grants normally. Granting a serializing instruction is the `RUN -> SER_WAIT` transition. In `ST_SER_WAIT` nothing is granted. The `SER_WAIT -> RUN` transition is taken when the in-flight count next becomes zero. Dispatch is strictly in program order, so a held slot 0 always holds slot 1 as well.

Top module: `dispatch_gate`

## Requirements
- R1: At most two instructions are granted per cycle. `grant[1]` is asserted only together with `grant[0]`. `adv_cnt` equals the number of grants (0, 1 or 2).
- R2: A slot is held when any of its enabled source registers is marked busy. It is also held when its enabled destination register is marked busy. Operands whose enable is low are ignored.
- R3: Slot 1 is held when slot 0 has an enabled destination register and slot 1 reads or writes that same register.
- R4: A granted instruction with an enabled destination marks that register busy from the next cycle on. A writeback strobe (`wb_valid`, `wb_reg`) clears the bit from the next cycle on. If a set and a clear name the same register in one cycle, the register stays busy.
- R5: `rs_full` bit 0 belongs to the integer unit (unit code 0), bit 1 to the load/store unit (code 1) and bit 2 to the system-register unit (code 2). A slot whose unit's bit is set is held. Unit code 3 is never granted.
- R6: Slot 1 is held when it targets the same unit as slot 0.
- R7: A serializing instruction is granted only from slot 0, and only while the in-flight count is zero. Slot 1 is never granted alongside it. A serializing instruction in slot 1 is held.
- R8: After a serializing instruction is granted, no grant is made until a retirement brings the in-flight count to zero. Grants resume in the following cycle.
- R9: The in-flight count rises by the grants and falls by `retire_cnt` in each cycle. When the count equals MAX_INFLIGHT, slot 0 is held. When the count equals MAX_INFLIGHT-1, slot 1 is held.
- R10: After reset the scoreboard is empty, the count is zero and the controller is in `ST_RUN`, so two independent instructions are granted at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| s0_valid | input | 1 | Slot 0 holds an instruction |
| s0_unit | input | 2 | Slot 0 target unit code |
| s0_ra_en | input | 1 | Slot 0 first source used |
| s0_ra | input | RW | Slot 0 first source register |
| s0_rb_en | input | 1 | Slot 0 second source used |
| s0_rb | input | RW | Slot 0 second source register |
| s0_rd_en | input | 1 | Slot 0 writes a register |
| s0_rd | input | RW | Slot 0 destination register |
| s0_serial | input | 1 | Slot 0 is serializing |
| s1_valid | input | 1 | Slot 1 holds an instruction |
| s1_unit | input | 2 | Slot 1 target unit code |
| s1_ra_en | input | 1 | Slot 1 first source used |
| s1_ra | input | RW | Slot 1 first source register |
| s1_rb_en | input | 1 | Slot 1 second source used |
| s1_rb | input | RW | Slot 1 second source register |
| s1_rd_en | input | 1 | Slot 1 writes a register |
| s1_rd | input | RW | Slot 1 destination register |
| s1_serial | input | 1 | Slot 1 is serializing |
| rs_full | input | 3 | Reservation-station full flags per unit |
| wb_valid | input | 1 | Writeback strobe |
| wb_reg | input | RW | Register written back |
| retire_cnt | input | 2 | Instructions completed this cycle |
| grant | output | 2 | Per-slot dispatch grant |
| adv_cnt | output | 2 | Queue entries consumed this cycle |

## Verification
Several properties are checked by assertions on every cycle:
- in-order granting;
- a serializing grant never being paired;
- the silent cycle after a serializing grant;
- a granted destination reading busy on the next cycle;
- the in-flight count never passing its limit.

Other behaviour depends on chosen operand patterns and on timing across several cycles. This includes source and destination hazards, the slot-to-slot dependency, each unit's full flag, the same-unit hold, and the exact cycle in which dispatch resumes after serialization or a writeback. The directed bench scenarios are what demonstrate these.

// File: rtl/disp_pkg.sv
package disp_pkg;

    typedef enum logic [1:0] {
        U_INT  = 2'd0,
        U_LSU  = 2'd1,
        U_SYS  = 2'd2,
        U_NONE = 2'd3
    } unit_e;

    typedef enum logic {
        ST_RUN      = 1'b0,
        ST_SER_WAIT = 1'b1
    } disp_state_e;

    function automatic logic unit_blocked(input logic [1:0] unit, input logic [2:0] full);
        logic b;
        unique case (unit)
            U_INT:   b = full[0];
            U_LSU:   b = full[1];
            U_SYS:   b = full[2];
            default: b = 1'b1;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/disp_scoreboard.sv
module disp_scoreboard #(
    parameter int NREG   = 32,
    parameter int NSET   = 2,
    parameter int NQUERY = 6,
    localparam int RW    = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSET-1:0]   set_en,
    input  logic [RW-1:0]     set_reg [NSET],
    input  logic              clr_en,
    input  logic [RW-1:0]     clr_reg,
    input  logic [RW-1:0]     q_reg [NQUERY],
    output logic [NQUERY-1:0] q_busy
);

    logic [NREG-1:0] busy_q;
    logic [NREG-1:0] set_mask;
    logic [NREG-1:0] clr_mask;

    always_comb begin
        set_mask = '0;
        for (int i = 0; i < NSET; i++) begin
            if (set_en[i]) set_mask[set_reg[i]] = 1'b1;
        end
        clr_mask = '0;
        if (clr_en) clr_mask[clr_reg] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) busy_q <= '0;
        else        busy_q <= (busy_q & ~clr_mask) | set_mask;
    end

    for (genvar q = 0; q < NQUERY; q++) begin : g_query
        assign q_busy[q] = busy_q[q_reg[q]];
    end

    // R4: a granted writer reads as busy on the following cycle
    a_r4_set_busy: assert property (@(posedge clk) disable iff (!rst_n)
        set_en[0] |=> busy_q[$past(set_reg[0])]);

    // R4: a clear that no set shadows frees the register
    a_r4_clr_free: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_en && !(set_en[0] && set_reg[0] == clr_reg) && !(set_en[1] && set_reg[1] == clr_reg))
        |=> !busy_q[$past(clr_reg)]);

endmodule

// File: rtl/disp_inflight.sv
module disp_inflight #(
    parameter int MAX_INFLIGHT = 8,
    localparam int CW = $clog2(MAX_INFLIGHT + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    add,
    input  logic [1:0]    sub,
    output logic [CW-1:0] cnt,
    output logic [CW-1:0] cnt_nxt
);

    assign cnt_nxt = cnt + {{(CW-2){1'b0}}, add} - {{(CW-2){1'b0}}, sub};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt <= '0;
        else        cnt <= cnt_nxt;
    end

    // R9: the in-flight count never exceeds its limit
    a_r9_cnt_bound: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= CW'(MAX_INFLIGHT));

endmodule

// File: rtl/dispatch_gate.sv
module dispatch_gate
    import disp_pkg::*;
#(
    parameter int NREG         = 32,
    parameter int MAX_INFLIGHT = 8,
    localparam int RW          = $clog2(NREG)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          s0_valid,
    input  logic [1:0]    s0_unit,
    input  logic          s0_ra_en,
    input  logic [RW-1:0] s0_ra,
    input  logic          s0_rb_en,
    input  logic [RW-1:0] s0_rb,
    input  logic          s0_rd_en,
    input  logic [RW-1:0] s0_rd,
    input  logic          s0_serial,
    input  logic          s1_valid,
    input  logic [1:0]    s1_unit,
    input  logic          s1_ra_en,
    input  logic [RW-1:0] s1_ra,
    input  logic          s1_rb_en,
    input  logic [RW-1:0] s1_rb,
    input  logic          s1_rd_en,
    input  logic [RW-1:0] s1_rd,
    input  logic          s1_serial,
    input  logic [2:0]    rs_full,
    input  logic          wb_valid,
    input  logic [RW-1:0] wb_reg,
    input  logic [1:0]    retire_cnt,
    output logic [1:0]    grant,
    output logic [1:0]    adv_cnt
);

    localparam int CW = $clog2(MAX_INFLIGHT + 1);
    localparam logic [CW-1:0] CNT_MAX  = CW'(MAX_INFLIGHT);
    localparam logic [CW-1:0] CNT_MAX1 = CW'(MAX_INFLIGHT - 1);

    disp_state_e   state_q, state_nxt;
    logic [5:0]    busy;
    logic [RW-1:0] q_reg [6];
    logic [RW-1:0] set_reg [2];
    logic [1:0]    set_en;
    logic [CW-1:0] cnt, cnt_nxt;
    logic          haz0, haz1, pair_dep, ok0, ok1;

    assign q_reg[0]   = s0_ra;
    assign q_reg[1]   = s0_rb;
    assign q_reg[2]   = s0_rd;
    assign q_reg[3]   = s1_ra;
    assign q_reg[4]   = s1_rb;
    assign q_reg[5]   = s1_rd;
    assign set_reg[0] = s0_rd;
    assign set_reg[1] = s1_rd;
    assign set_en     = {grant[1] & s1_rd_en, grant[0] & s0_rd_en};

    disp_scoreboard #(.NREG(NREG), .NSET(2), .NQUERY(6)) u_sb (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (set_en),
        .set_reg (set_reg),
        .clr_en  (wb_valid),
        .clr_reg (wb_reg),
        .q_reg   (q_reg),
        .q_busy  (busy)
    );

    disp_inflight #(.MAX_INFLIGHT(MAX_INFLIGHT)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .add     (adv_cnt),
        .sub     (retire_cnt),
        .cnt     (cnt),
        .cnt_nxt (cnt_nxt)
    );

    // readiness of each slot, independent of controller state
    always_comb begin
        haz0 = (s0_ra_en & busy[0]) | (s0_rb_en & busy[1]) | (s0_rd_en & busy[2]);
        haz1 = (s1_ra_en & busy[3]) | (s1_rb_en & busy[4]) | (s1_rd_en & busy[5]);
        pair_dep = s0_rd_en & ((s1_ra_en & (s1_ra == s0_rd)) |
                               (s1_rb_en & (s1_rb == s0_rd)) |
                               (s1_rd_en & (s1_rd == s0_rd)));
        ok0 = s0_valid & ~haz0 & ~unit_blocked(s0_unit, rs_full) &
              (cnt < CNT_MAX) & (~s0_serial | (cnt == '0));
        ok1 = s1_valid & ~haz1 & ~pair_dep & ~unit_blocked(s1_unit, rs_full) &
              (cnt < CNT_MAX1) & ~s0_serial & ~s1_serial & (s1_unit != s0_unit);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_nxt;
    end

    // outputs and next state
    always_comb begin
        grant     = 2'b00;
        state_nxt = state_q;
        unique case (state_q)
            ST_RUN: begin
                grant = {ok0 & ok1, ok0};
                if (ok0 && s0_serial) state_nxt = ST_SER_WAIT;
            end
            ST_SER_WAIT: begin
                if (cnt_nxt == '0) state_nxt = ST_RUN;
            end
            default: state_nxt = ST_RUN;
        endcase
        adv_cnt = {1'b0, grant[0]} + {1'b0, grant[1]};
    end

    // R1: slot 1 never leaves ahead of slot 0
    a_r1_in_order: assert property (@(posedge clk) disable iff (!rst_n)
        grant[1] |-> grant[0]);

    // R7: a serializing grant is never paired
    a_r7_serial_alone: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[0] && s0_serial) |-> !grant[1]);

    // R8: the cycle after a serializing grant is silent
    a_r8_quiet_after: assert property (@(posedge clk) disable iff (!rst_n)
        (grant[0] && s0_serial) |=> (grant == 2'b00));

endmodule

// File: tb/dispatch_gate_bench.sv
`timescale 1ns/100ps
module dispatch_gate_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       s0_valid, s0_ra_en, s0_rb_en, s0_rd_en, s0_serial;
    logic       s1_valid, s1_ra_en, s1_rb_en, s1_rd_en, s1_serial;
    logic [1:0] s0_unit, s1_unit;
    logic [4:0] s0_ra, s0_rb, s0_rd, s1_ra, s1_rb, s1_rd;
    logic [2:0] rs_full;
    logic       wb_valid;
    logic [4:0] wb_reg;
    logic [1:0] retire_cnt;
    logic [1:0] grant, adv_cnt;

    int checks = 0;
    int fails  = 0;
    int infl   = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    dispatch_gate u_dispatch_gate (
        .clk(clk), .rst_n(rst_n),
        .s0_valid(s0_valid), .s0_unit(s0_unit), .s0_ra_en(s0_ra_en), .s0_ra(s0_ra),
        .s0_rb_en(s0_rb_en), .s0_rb(s0_rb), .s0_rd_en(s0_rd_en), .s0_rd(s0_rd),
        .s0_serial(s0_serial),
        .s1_valid(s1_valid), .s1_unit(s1_unit), .s1_ra_en(s1_ra_en), .s1_ra(s1_ra),
        .s1_rb_en(s1_rb_en), .s1_rb(s1_rb), .s1_rd_en(s1_rd_en), .s1_rd(s1_rd),
        .s1_serial(s1_serial),
        .rs_full(rs_full), .wb_valid(wb_valid), .wb_reg(wb_reg), .retire_cnt(retire_cnt),
        .grant(grant), .adv_cnt(adv_cnt)
    );

    // unit codes: 0 integer, 1 load/store, 2 system-register, 3 none
    task automatic set_s0(input logic v, input logic [1:0] u,
                          input logic ae, input logic [4:0] a,
                          input logic be, input logic [4:0] b,
                          input logic de, input logic [4:0] d, input logic ser);
        s0_valid = v; s0_unit = u; s0_ra_en = ae; s0_ra = a;
        s0_rb_en = be; s0_rb = b; s0_rd_en = de; s0_rd = d; s0_serial = ser;
    endtask

    task automatic set_s1(input logic v, input logic [1:0] u,
                          input logic ae, input logic [4:0] a,
                          input logic be, input logic [4:0] b,
                          input logic de, input logic [4:0] d, input logic ser);
        s1_valid = v; s1_unit = u; s1_ra_en = ae; s1_ra = a;
        s1_rb_en = be; s1_rb = b; s1_rd_en = de; s1_rd = d; s1_serial = ser;
    endtask

    task automatic idle();
        set_s0(0, 0, 0, 0, 0, 0, 0, 0, 0);
        set_s1(0, 0, 0, 0, 0, 0, 0, 0, 0);
        rs_full = 3'b000; wb_valid = 0; wb_reg = 0; retire_cnt = 0;
    endtask

    // check grant and adv_cnt before the edge, then clock once
    task automatic check_step(input logic [1:0] exp, input string req);
        int n;
        #1;
        n = exp[0] + exp[1];
        checks++;
        if (grant !== exp) begin
            fails++;
            $display("FAIL %s grant actual=%b expected=%b", req, grant, exp);
        end
        checks++;
        if (adv_cnt !== 2'(n)) begin
            fails++;
            $display("FAIL %s adv_cnt actual=%0d expected=%0d", req, adv_cnt, n);
        end
        infl = infl + n - int'(retire_cnt);
        @(posedge clk);
        @(negedge clk);
        wb_valid = 0; retire_cnt = 0;
    endtask

    task automatic drain();
        idle();
        while (infl > 0) begin
            retire_cnt = (infl > 3) ? 2'd3 : 2'(infl);
            check_step(2'b00, "drain");
        end
    endtask

    task automatic t_reset();
        idle();
        set_s0(1, 0, 1, 2, 1, 3, 1, 1, 0);
        set_s1(1, 1, 1, 5, 0, 0, 1, 4, 0);
        check_step(2'b11, "R10 R1 pair after reset");
    endtask

    task automatic t_busy();
        idle();
        set_s0(1, 0, 1, 1, 0, 0, 0, 0, 0);
        check_step(2'b00, "R2 busy source");
        set_s1(1, 1, 0, 0, 0, 0, 0, 0, 0);
        check_step(2'b00, "R1 slot1 held behind slot0");
        set_s1(0, 0, 0, 0, 0, 0, 0, 0, 0);
        set_s0(1, 0, 0, 0, 0, 0, 1, 4, 0);
        check_step(2'b00, "R2 busy destination");
        set_s0(1, 0, 1, 1, 0, 0, 0, 0, 0);
        wb_valid = 1; wb_reg = 1;
        check_step(2'b00, "R4 writeback not visible same cycle");
        wb_valid = 1; wb_reg = 4; retire_cnt = 2;
        check_step(2'b01, "R4 writeback clears next cycle");
        drain();
    endtask

    task automatic t_pair();
        idle();
        set_s0(1, 0, 0, 0, 0, 0, 1, 6, 0);
        set_s1(1, 1, 1, 6, 0, 0, 0, 0, 0);
        check_step(2'b01, "R3 slot1 reads slot0 dest");
        set_s0(1, 1, 1, 6, 0, 0, 0, 0, 0);
        set_s1(0, 0, 0, 0, 0, 0, 0, 0, 0);
        wb_valid = 1; wb_reg = 6; retire_cnt = 1;
        check_step(2'b00, "R4 granted dest now busy");
        set_s0(1, 0, 0, 0, 0, 0, 1, 7, 0);
        set_s1(1, 1, 0, 0, 0, 0, 1, 7, 0);
        check_step(2'b01, "R3 slot1 writes slot0 dest");
        set_s0(1, 0, 0, 0, 0, 0, 1, 8, 0);
        set_s1(1, 1, 1, 9, 0, 8, 0, 0, 0);
        wb_valid = 1; wb_reg = 7; retire_cnt = 1;
        check_step(2'b11, "R2 R3 disabled operand ignored");
        idle();
        wb_valid = 1; wb_reg = 8;
        check_step(2'b00, "R4 clear r8");
        set_s0(1, 0, 0, 0, 0, 0, 1, 10, 0);
        wb_valid = 1; wb_reg = 10;
        check_step(2'b01, "R4 set and clear same reg");
        set_s0(1, 0, 1, 10, 0, 0, 0, 0, 0);
        check_step(2'b00, "R4 set wins over clear");
        idle();
        wb_valid = 1; wb_reg = 10;
        check_step(2'b00, "R4 clear r10");
        drain();
    endtask

    task automatic t_full();
        idle();
        rs_full = 3'b001;
        set_s0(1, 0, 0, 0, 0, 0, 0, 0, 0);
        check_step(2'b00, "R5 integer station full");
        set_s0(1, 1, 0, 0, 0, 0, 0, 0, 0);
        set_s1(1, 0, 0, 0, 0, 0, 0, 0, 0);
        check_step(2'b01, "R5 slot1 integer full");
        rs_full = 3'b100;
        set_s1(1, 2, 0, 0, 0, 0, 0, 0, 0);
        check_step(2'b01, "R5 slot1 system full");
        rs_full = 3'b010;
        check_step(2'b00, "R5 load/store full");
        rs_full = 3'b000;
        check_step(2'b11, "R5 nothing full");
        set_s0(1, 3, 0, 0, 0, 0, 0, 0, 0);
        set_s1(0, 0, 0, 0, 0, 0, 0, 0, 0);
        check_step(2'b00, "R5 unit code 3");
        set_s0(1, 0, 0, 0, 0, 0, 0, 0, 0);
        set_s1(1, 0, 0, 0, 0, 0, 0, 0, 0);
        check_step(2'b01, "R6 same unit both slots");
        drain();
    endtask

    task automatic t_serial();
        idle();
        set_s0(1, 0, 0, 0, 0, 0, 0, 0, 0);
        set_s1(1, 2, 0, 0, 0, 0, 0, 0, 1);
        check_step(2'b01, "R7 serializing in slot1 held");
        set_s0(1, 2, 0, 0, 0, 0, 0, 0, 1);
        set_s1(0, 0, 0, 0, 0, 0, 0, 0, 0);
        check_step(2'b00, "R7 waits for empty");
        retire_cnt = 1;
        check_step(2'b00, "R7 count still one this cycle");
        set_s1(1, 0, 0, 0, 0, 0, 0, 0, 0);
        check_step(2'b01, "R7 serializing goes alone");
        set_s0(1, 0, 0, 0, 0, 0, 0, 0, 0);
        set_s1(1, 1, 0, 0, 0, 0, 0, 0, 0);
        check_step(2'b00, "R8 nothing after serializing");
        retire_cnt = 1;
        check_step(2'b00, "R8 retire cycle still quiet");
        check_step(2'b11, "R8 dispatch resumes");
        drain();
    endtask

    task automatic t_limit();
        idle();
        set_s0(1, 0, 0, 0, 0, 0, 0, 0, 0);
        set_s1(1, 1, 0, 0, 0, 0, 0, 0, 0);
        for (int i = 0; i < 4; i++) check_step(2'b11, "R9 fill to limit");
        retire_cnt = 1;
        check_step(2'b00, "R9 count at limit");
        check_step(2'b01, "R9 count one below limit");
        drain();
    endtask

    initial begin
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_busy();
        t_pair();
        t_full();
        t_serial();
        t_limit();
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule